// File: doc/BRIEF.md
# Timer Prescaler Reset and Synchronization Control

This block holds the general control byte of a timer, together with the timer's clock prescaler that control byte governs. Software writes the byte through a single-cycle write strobe and reads it back combinationally. One bit requests a prescaler restart. Another bit selects a synchronization mode. In that mode the restart request is held rather than dropped, so the timer stays frozen while software configures it. A third bit is a stored pin-routing selector that the block passes out unchanged.

In the normal case the restart request lasts exactly one cycle and then clears itself in hardware. With the synchronization bit set, the request stays latched until software writes the synchronization bit back to zero, and the prescaler starts counting from zero on that write. While the request is active, the prescaler count is held at zero and no tick enables are produced. When it is free to run, the prescaler produces a tick enable once every 1, 8, 64, 256 or 1024 clocks, as chosen by a 3-bit select. A select value of 0 means stopped.

Top module: `tmr_sync_ctl`

## Requirements
- R1: After a synchronous active-low reset, the control byte reads 0x00, the prescaler restart output is low and the remap output is low.
- R2: A write stores bit 7 (synchronization mode) and bit 1 (remap), and both read back at the same positions. Bits 6 to 2 are ignored and always read as zero.
- R3: A write with bit 0 = 1 and bit 7 = 0 asserts the prescaler restart output for exactly the one cycle after the write, after which hardware clears it.
- R4: A write with bit 0 = 1 and bit 7 = 1 keeps the restart output asserted for as long as no further write occurs.
- R5: A later write with bit 7 = 0 and bit 0 = 0 releases a held restart, and the prescaler resumes counting from zero.
- R6: Bit 0 of the read data is 1 only while a restart is being held in synchronization mode. A self-clearing restart reads as 0.
- R7: While the restart output is high, the prescaler count is held at zero and the tick output stays low.
- R8: Select values 1, 2, 3, 4 and 5 give a tick period of 1, 8, 64, 256 and 1024 clocks respectively.
- R9: Select value 0, and the unused values 6 and 7, produce no ticks.
- R10: After a restart, the first tick comes when the count first reaches the division minus one. That is 8 cycles after a one-cycle restart write for divide-by-8, and division minus one cycles after a release write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Control byte write strobe |
| wr_data | input | 8 | Control byte write value |
| rd_data | output | 8 | Control byte read value |
| clk_sel | input | 3 | Prescaler division select |
| remap | output | 1 | Stored pin-routing selector |
| psc_rst | output | 1 | Prescaler restart, active high |
| tick | output | 1 | Timer tick enable, one cycle wide |

## Verification
The assertions take for granted that the write strobe and write data are settled before the clock edge, and that no write lands in the cycle being judged for the self-clear and hold properties, which is why both properties require the write strobe to be low. The stimulus drives every input at the falling edge and issues each write as a single-cycle strobe. The prescaler select changes only while a restart is active or just before a restart, so that each measured tick interval starts from a known count of zero.

// File: rtl/tsc_pkg.sv
// Package: shared bit positions and division table for the timer
// synchronization control block. Assumes an 8-bit control byte.
package tsc_pkg;
    localparam int BIT_SYNC  = 7;
    localparam int BIT_REMAP = 1;
    localparam int BIT_PSR   = 0;
    localparam int NUM_DIV   = 5;

    // Returns log2 of the division for select value (idx + 1).
    function automatic int div_shift(input int idx);
        case (idx)
            0:       return 0;
            1:       return 3;
            2:       return 6;
            3:       return 8;
            default: return 10;
        endcase
    endfunction
endpackage

// File: rtl/tsc_regctl.sv
// Module: control byte storage with a self-clearing or held restart bit.
// Assumes wr_en_i is a single-cycle strobe synchronous to clk.
module tsc_regctl #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              remap_o,
    output logic              psc_rst_o
);
    import tsc_pkg::*;

    logic sync_q;
    logic remap_q;
    logic rst_bit_q;

    // Capture written fields; drop the restart bit when not in sync mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q    <= 1'b0;
            remap_q   <= 1'b0;
            rst_bit_q <= 1'b0;
        end else if (wr_en_i) begin
            sync_q    <= wr_data_i[BIT_SYNC];
            remap_q   <= wr_data_i[BIT_REMAP];
            rst_bit_q <= wr_data_i[BIT_PSR];
        end else if (!sync_q) begin
            rst_bit_q <= 1'b0;
        end
    end

    // Assemble the read value; the restart bit shows only while held.
    always_comb begin
        rd_data_o            = '0;
        rd_data_o[BIT_SYNC]  = sync_q;
        rd_data_o[BIT_REMAP] = remap_q;
        rd_data_o[BIT_PSR]   = rst_bit_q & sync_q;
    end

    assign remap_o   = remap_q;
    assign psc_rst_o = rst_bit_q;

    // R3
    selfclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_bit_q && !sync_q && !wr_en_i) |=> !rst_bit_q);

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_bit_q && sync_q && !wr_en_i) |=> rst_bit_q);
endmodule

// File: rtl/tsc_prescale.sv
// Module: free-running prescaler counter with selectable tick enables.
// Assumes psc_rst_i comes from a register in the same clock domain.
module tsc_prescale #(
    parameter int CNT_W = 10,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             psc_rst_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);
    import tsc_pkg::*;

    logic [CNT_W-1:0]   cnt_q;
    logic [NUM_DIV-1:0] hit;

    // Advance the count, or pin it at zero while restart is active.
    always_ff @(posedge clk) begin
        if (!rst_n || psc_rst_i) cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
    end

    // One terminal-count detector for each division.
    for (genvar g = 0; g < NUM_DIV; g++) begin : g_hit
        localparam int SH = div_shift(g);
        if (SH == 0) begin : g_every
            assign hit[g] = 1'b1;
        end else begin : g_mask
            assign hit[g] = &cnt_q[SH-1:0];
        end
    end

    // Pick the selected detector; zero and unused selects stay quiet.
    always_comb begin
        tick_o = 1'b0;
        for (int i = 0; i < NUM_DIV; i++) begin
            if (int'(sel_i) == i + 1) tick_o = hit[i] & ~psc_rst_i;
        end
    end

    // R7
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        psc_rst_i |=> (cnt_q == '0));
endmodule

// File: rtl/tmr_sync_ctl.sv
// Module: top of the timer prescaler restart and synchronization control.
// Joins the control register to the prescaler. Assumes a single clock.
module tmr_sync_ctl #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 10,
    parameter int SEL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic [SEL_W-1:0]  clk_sel,
    output logic              remap,
    output logic              psc_rst,
    output logic              tick
);
    tsc_regctl #(.DATA_W(DATA_W)) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_data_i (wr_data),
        .rd_data_o (rd_data),
        .remap_o   (remap),
        .psc_rst_o (psc_rst)
    );

    tsc_prescale #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_psc (
        .clk       (clk),
        .rst_n     (rst_n),
        .psc_rst_i (psc_rst),
        .sel_i     (clk_sel),
        .tick_o    (tick)
    );

    // R7
    halt_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        psc_rst |-> !tick);

    // R6
    rdback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[0] |-> psc_rst);
endmodule

// File: tb/tmr_sync_ctl_bench.sv
module tmr_sync_ctl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [2:0] clk_sel = 3'd1;
    logic       remap, psc_rst, tick;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tmr_sync_ctl u_tmr_sync_ctl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .clk_sel(clk_sel), .remap(remap),
        .psc_rst(psc_rst), .tick(tick)
    );

    // Vector fields: {wr_en, wr_data[7:0], exp_rd[7:0], exp_psc_rst, exp_tick}, select 1
    localparam logic [18:0] VEC [14] = '{
        {1'b0, 8'h00, 8'h00, 1'b0, 1'b1},   // R1 idle
        {1'b1, 8'h01, 8'h00, 1'b1, 1'b0},   // R3 R6 pulse
        {1'b0, 8'h00, 8'h00, 1'b0, 1'b1},   // R3 cleared
        {1'b1, 8'h81, 8'h81, 1'b1, 1'b0},   // R4 hold
        {1'b0, 8'h00, 8'h81, 1'b1, 1'b0},   // R4
        {1'b0, 8'h00, 8'h81, 1'b1, 1'b0},   // R4 R7
        {1'b1, 8'h80, 8'h80, 1'b0, 1'b1},   // R5 release
        {1'b1, 8'h81, 8'h81, 1'b1, 1'b0},   // R4
        {1'b1, 8'h00, 8'h00, 1'b0, 1'b1},   // R5
        {1'b1, 8'h83, 8'h83, 1'b1, 1'b0},   // R2 remap
        {1'b1, 8'h02, 8'h02, 1'b0, 1'b1},   // R2 R5
        {1'b1, 8'h03, 8'h02, 1'b1, 1'b0},   // R3 R6
        {1'b0, 8'h00, 8'h02, 1'b0, 1'b1},   // R3
        {1'b1, 8'h7C, 8'h00, 1'b0, 1'b1}    // R2 ignored bits
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One cycle from falling edge to falling edge with optional write
    task automatic step(input logic w, input logic [7:0] d);
        wr_en = w;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Count falling edges until tick is seen
    task automatic meas(output int n);
        n = 0;
        while (!tick && n < 3000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int n;
        int cnt;
        int sh;
        @(negedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 rd", rd_data, 8'h00);
        chk("R1 psc_rst", psc_rst, 1'b0);
        chk("R1 remap", remap, 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < 14; i++) begin
            step(VEC[i][18], VEC[i][17:10]);
            chk($sformatf("vec%0d rd R2/R6", i), rd_data, VEC[i][9:2]);
            chk($sformatf("vec%0d psc_rst R3/R4/R5", i), psc_rst, VEC[i][1]);
            chk($sformatf("vec%0d tick R7", i), tick, VEC[i][0]);
        end

        // R8 R10: one-cycle restart, then first tick and period per select
        for (int s = 1; s <= 5; s++) begin
            sh = (s == 1) ? 0 : (s == 2) ? 3 : (s == 3) ? 6 : (s == 4) ? 8 : 10;
            clk_sel = 3'(s);
            step(1'b1, 8'h01);
            meas(n);
            chk($sformatf("R10 first tick sel%0d", s), n, 1 << sh);
            step(1'b0, 8'h00);
            meas(n);
            chk($sformatf("R8 period sel%0d", s), n + 1, 1 << sh);
        end

        // R9: stopped and unused selects give no ticks
        foreach (clk_sel[k]) begin end
        for (int s = 0; s < 8; s += 6) begin
            clk_sel = 3'(s);
            step(1'b1, 8'h01);
            cnt = 0;
            for (int c = 0; c < 1100; c++) begin
                step(1'b0, 8'h00);
                if (tick) cnt++;
            end
            chk($sformatf("R9 ticks sel%0d", s), cnt, 0);
        end
        clk_sel = 3'd7;
        step(1'b0, 8'h00);
        chk("R9 sel7", tick, 1'b0);

        // R4 R7: held restart blocks ticks for a long time
        clk_sel = 3'd1;
        step(1'b1, 8'h81);
        cnt = 0;
        for (int c = 0; c < 2000; c++) begin
            step(1'b0, 8'h00);
            if (tick || !psc_rst) cnt++;
        end
        chk("R4 R7 held no tick", cnt, 0);
        chk("R6 held readback", rd_data[0], 1'b1);

        // R5 R10: release write restarts count from zero
        clk_sel = 3'd3;
        step(1'b1, 8'h00);
        chk("R5 released", psc_rst, 1'b0);
        meas(n);
        chk("R10 first tick after release sel3", n, 63);

        // R1: reset mid-operation clears held state
        step(1'b1, 8'h83);
        rst_n = 1'b0;
        step(1'b0, 8'h00);
        rst_n = 1'b1;
        chk("R1 rd after reset", rd_data, 8'h00);
        chk("R1 psc_rst after reset", psc_rst, 1'b0);
        chk("R1 remap after reset", remap, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule